// File: doc/BRIEF.md
# Serial Addressed Configuration Port

This block receives configuration words over three wires: a serial clock, a serial data line and a load strobe. Bits are gathered into a 22-bit shift register, the most significant bit first, one bit per rising edge of the serial clock. A rising edge on the load strobe then commits the word. The two bits shifted in last pick one of four configuration registers. The other twenty bits become that register's new contents.

All three serial inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and edges are found in the system clock domain. The four registers drive the rest of the synthesizer in parallel. Nothing in the register contents ever blocks the load path. Power-down flags kept in these registers therefore never stop a later write from landing.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset, and again after any later reset, all four configuration registers read zero.
- R2: The shift register takes one bit per rising edge of the serial clock, and only then. The first bit sent ends up as word bit 21.
- R3: Word bits 1:0 (the last two bits sent) select the destination register. The value 0 selects `cfg_regs[0]`, 1 selects `cfg_regs[1]`, 2 selects `cfg_regs[2]` and 3 selects `cfg_regs[3]`.
- R4: On a load, word bits 21:2 are written to the selected register. Word bit 21 lands in payload bit 19, and word bit 2 lands in payload bit 0.
- R5: A load writes exactly one register and the other three keep their values. Serial clocks with no load, and a falling edge of the load strobe, change no register.
- R6: Writes are accepted whatever the registers hold, including every register set to all ones with the power-down flags active.
- R7: Each serial input phase must last at least 3 system clock cycles. A write is visible on `cfg_regs` no later than 4 system clock cycles after the load strobe rises.
- R8: If more than 22 bits are sent before a load, only the last 22 bits take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_load | input | 1 | Load strobe; its rising edge commits the word |
| cfg_regs | output | 4 x 20 | The four configuration registers, index = address |

## Verification
The main stimulus sweeps every address against a walking-one payload, plus all-zeros, all-ones and an alternating pattern. The walking ones would expose any swapped or shifted payload bit. The sweep over addresses would expose a decode error or a write that leaks into a neighbouring register. Further patterns cover a stream longer than one word, serial clocks with no load, a second word sent while the strobe stays high and then released, and writes after every register has been set to all ones. Together these separate a correct edge-triggered commit from one that is level-sensitive or triggers on the wrong edge. The load-to-output delay is checked on every write.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int CFG_WORD_W = 22;
  localparam int CFG_ADDR_W = 2;
  localparam int CFG_PAY_W  = CFG_WORD_W - CFG_ADDR_W;
  localparam int CFG_NREGS  = 1 << CFG_ADDR_W;

  // Address field: the low bits, i.e. the last ones shifted in.
  function automatic logic [CFG_ADDR_W-1:0] word_addr(input logic [CFG_WORD_W-1:0] w);
    return w[CFG_ADDR_W-1:0];
  endfunction

  // Payload field: everything above the address.
  function automatic logic [CFG_PAY_W-1:0] word_payload(input logic [CFG_WORD_W-1:0] w);
    return w[CFG_WORD_W-1:CFG_ADDR_W];
  endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out,
  output logic [W-1:0] rise
);
  // Stage STAGES holds the previous synchronized value for edge detection.
  logic [STAGES:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= '0;
    else        pipe[0] <= async_in;
  end

  for (genvar s = 1; s <= STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s] <= '0;
      else        pipe[s] <= pipe[s-1];
    end
  end

  assign sync_out = pipe[STAGES-1];
  assign rise     = pipe[STAGES-1] & ~pipe[STAGES];

  for (genvar b = 0; b < W; b++) begin : g_chk
    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise[b] |=> !rise[b]); // R7
  end
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int WORD_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[WORD_W-2:0], bit_in};
  end

  AST_SHIFT_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word)); // R2
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_port_pkg::*;
#(
  parameter int WORD_W = CFG_WORD_W,
  parameter int ADDR_W = CFG_ADDR_W,
  localparam int PAY_W = WORD_W - ADDR_W,
  localparam int NREGS = 1 << ADDR_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_en,
  input  logic [WORD_W-1:0]          word,
  output logic [NREGS-1:0][PAY_W-1:0] regs
);
  logic [ADDR_W-1:0] sel_addr;
  logic [PAY_W-1:0]  sel_pay;
  logic [NREGS-1:0]  wr_en;

  assign sel_addr = word[ADDR_W-1:0];
  assign sel_pay  = word[WORD_W-1:ADDR_W];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    assign wr_en[i] = load_en && (sel_addr == ADDR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        regs[i] <= '0;
      else if (wr_en[i]) regs[i] <= sel_pay;
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[i] |=> regs[i] == $past(word[WORD_W-1:ADDR_W])); // R4
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en)); // R5
  AST_LOAD_ACTIVE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> $countones(wr_en) == 1); // R3
  AST_NO_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(regs)); // R5
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import cfg_port_pkg::*;
#(
  parameter int WORD_W      = CFG_WORD_W,
  parameter int ADDR_W      = CFG_ADDR_W,
  parameter int SYNC_STAGES = 2,
  localparam int PAY_W      = WORD_W - ADDR_W,
  localparam int NREGS      = 1 << ADDR_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ser_clk,
  input  logic                        ser_dat,
  input  logic                        ser_load,
  output logic [NREGS-1:0][PAY_W-1:0] cfg_regs
);
  localparam int SIG_CLK = 0;
  localparam int SIG_DAT = 1;
  localparam int SIG_LD  = 2;

  logic [2:0]        pins, pins_sync, pins_rise;
  logic              sclk_rise, load_rise, dat_s;
  logic [WORD_W-1:0] shift_word;

  assign pins = {ser_load, ser_dat, ser_clk};

  // Data goes through the same depth as the clock so both stay aligned.
  cfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pins),
    .sync_out (pins_sync),
    .rise     (pins_rise)
  );

  assign sclk_rise = pins_rise[SIG_CLK];
  assign load_rise = pins_rise[SIG_LD];
  assign dat_s     = pins_sync[SIG_DAT];

  cfg_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (sclk_rise),
    .bit_in   (dat_s),
    .word     (shift_word)
  );

  cfg_regbank #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_rise),
    .word    (shift_word),
    .regs    (cfg_regs)
  );

  AST_SHIFT_TAKES_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> shift_word[0] == $past(dat_s)); // R2
  AST_REGS_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_rise |=> $stable(cfg_regs)); // R5
endmodule

// File: tb/serial_cfg_port_test.sv
module serial_cfg_port_test;
  localparam int WW = 22;
  localparam int PW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_load = 1'b0;
  logic [3:0][PW-1:0] cfg_regs;
  logic [PW-1:0] exp_r [4];
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serial_cfg_port uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_load(ser_load), .cfg_regs(cfg_regs)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 4; i++) begin
      n_checks++;
      if (cfg_regs[i] !== exp_r[i]) begin
        n_fail++;
        $display("FAIL %s reg%0d actual=%05h expected=%05h", req, i, cfg_regs[i], exp_r[i]);
      end
    end
  endtask

  task automatic send_bits(input logic [63:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = bits[i];
      tick(3);
      ser_clk = 1'b1;
      tick(3);
      ser_clk = 1'b0;
    end
  endtask

  // Rising load edge; the expected value is the word sent, split arithmetically.
  task automatic commit(input logic [WW-1:0] w, input string req);
    exp_r[w % 4] = PW'(w / 4);
    ser_load = 1'b1;
    tick(4);
    check_all(req); // R7: visible within 4 cycles
    ser_load = 1'b0;
    tick(3);
  endtask

  task automatic write_reg(input int a, input logic [PW-1:0] p, input string req);
    logic [WW-1:0] w;
    w = WW'(p) * 4 + WW'(a);
    send_bits(64'(w), WW);
    commit(w, req);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) exp_r[i] = '0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    check_all("R1 reset");

    // Sweep addresses and payload patterns (R2 R3 R4 R5 R7)
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < PW; b++) write_reg(a, PW'(1) << b, "R4 walking one");
      write_reg(a, 20'hA5A5A, "R3 pattern");
      write_reg(a, 20'h0, "R2 zeros");
    end

    // Serial clocks with no load change nothing (R5)
    send_bits(64'h3FFFFF, WW);
    tick(6);
    check_all("R5 clocks without load");

    // Falling edge of load has no effect (R5)
    write_reg(1, 20'h12345, "R5 setup");
    ser_load = 1'b1;
    tick(4);
    send_bits(64'((WW'(20'hFEDCB) * 4) + 1), WW);
    ser_load = 1'b0;
    tick(6);
    check_all("R5 falling edge ignored");

    // Over-long stream: only the last 22 bits count (R8)
    begin
      logic [WW-1:0] w;
      w = WW'(20'h0F0F1) * 4 + 2;
      send_bits({34'h0, 8'hFF, w}, WW + 8);
      commit(w, "R8 long stream");
    end

    // All ones everywhere (power-down flags set), then writes still land (R6)
    for (int a = 0; a < 4; a++) write_reg(a, 20'hFFFFF, "R6 all ones");
    for (int a = 3; a >= 0; a--) write_reg(a, PW'(20'h1111 * (a + 1)), "R6 write after power-down");

    // Reset clears everything again (R1)
    tick(2);
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) exp_r[i] = '0;
    tick(2);
    rst_n = 1'b1;
    tick(2);
    check_all("R1 second reset");

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(negedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule